// File: doc/BRIEF.md
# Window Watchdog with Mode Supervision

This block supervises a microcontroller through three operating modes: Reset, Normal Request and Normal. While in Reset it holds a reset request to the MCU for a fixed number of cycles. It then moves to Normal Request. There the MCU must issue a clear within a fixed startup timeout to reach Normal. In Normal a window watchdog runs. Its period is split into a closed first half and an open second half. A clear in the open half restarts the period. A clear in the closed half, or no clear before the period ends, sends the block back to Reset.

The clear arrives as a one-cycle strobe, already decoded from a write to the mode field of a control register. A two-bit configuration code says where the timebase comes from: a precise external reference, a strap to ground that turns the watchdog off, or nothing valid, in which case a shorter internal fallback base is used. The code is sampled only while in Reset, and two status flags report what was latched. A prescaler select multiplies the base period by a power of two. All durations are parameters given in clock cycles.

Top module: `wdt_supervisor`

## Requirements
- R1: On reset the mode output reads Reset and the status flags read 0. Mode encoding is 0 = Reset, 1 = Normal Request, 2 = Normal. Reset is held for RST_HOLD cycles after release, and the block then enters Normal Request when the watchdog is not strapped off.
- R2: In Normal, a clear strobe in window cycle k with k >= P/2 keeps the mode Normal and restarts the window, so an unserviced window then lasts P more cycles. P is the window period and k counts from 0 at the start of the window.
- R3: In Normal, a clear strobe in window cycle k with k < P/2 sends the mode to Reset on the next cycle.
- R4: In Normal with no clear, the mode stays Normal for exactly P cycles and then becomes Reset.
- R5: In Normal Request, a clear strobe moves the mode to Normal on the next cycle. With no clear, the mode becomes Reset after REQ_TICKS cycles and returns to Normal Request after the reset hold.
- R6: P equals the base period shifted left by prescSel (prescSel = 0..3 gives a factor of 1, 2, 4 or 8).
- R7: cfgCode 1 (strapped to ground) makes Reset exit straight to Normal and sets wdOff to 1. In that state clears and elapsed time never cause a reset.
- R8: cfgCode 0 selects the external base BASE_TICKS with refFault 0. cfgCode 2 or 3 (no valid reference) selects FALLBACK_TICKS and sets refFault to 1.
- R9: cfgCode is sampled only while in Reset. A change made in another mode leaves wdOff, refFault and the window period unchanged until the next Reset.
- R10: mcuRst is 1 exactly while the mode is Reset, and every entry to Reset lasts RST_HOLD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| clrStb | input | 1 | One-cycle watchdog clear strobe |
| prescSel | input | PRESC_W | Period prescaler select (shift amount) |
| cfgCode | input | 2 | Timebase configuration: 0 external, 1 strapped off, 2/3 missing |
| mcuRst | output | 1 | Reset request to the MCU |
| mode | output | 2 | Current mode: 0 Reset, 1 Normal Request, 2 Normal |
| wdOff | output | 1 | Watchdog disabled by strap (latched in Reset) |
| refFault | output | 1 | Reference missing, fallback base in use (latched in Reset) |

## Verification
A wrong window counter shows at the mode port within one period. The bench finds it as an early or late return to Reset, or as an accepted clear on the wrong side of the half-period boundary. That boundary is swept cycle by cycle for two base periods. A wrong configuration latch shows at once in wdOff or refFault, and within one period as a wrong overflow time. A broken Reset-hold or startup counter changes the measured length of the Reset or Normal Request interval on its first occurrence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    MODE_RESET  = 2'd0,
    MODE_NREQ   = 2'd1,
    MODE_NORMAL = 2'd2
  } wdt_mode_e;

  localparam logic [1:0] CFG_EXT = 2'd0;
  localparam logic [1:0] CFG_GND = 2'd1;

  // control -> datapath
  typedef struct packed {
    logic holdRun;
    logic reqRun;
    logic winRun;
    logic winRestart;
  } wdt_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic holdLast;
    logic reqLast;
    logic winOpen;
    logic winLast;
  } wdt_flags_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS     = 40,
  parameter int FALLBACK_TICKS = 24,
  parameter int REQ_TICKS      = 30,
  parameter int RST_HOLD       = 4,
  parameter int PRESC_W        = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  wdt_strobe_t        stb,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic               useFallback,
  output wdt_flags_t         flags
);

  localparam int MAX_BASE   = (BASE_TICKS > FALLBACK_TICKS) ? BASE_TICKS : FALLBACK_TICKS;
  localparam int MAX_PERIOD = MAX_BASE << ((1 << PRESC_W) - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);
  localparam int HOLD_W     = $clog2(RST_HOLD + 1);
  localparam int REQ_W      = $clog2(REQ_TICKS + 1);

  logic [CNT_W-1:0]  winCnt;
  logic [CNT_W-1:0]  baseSel;
  logic [CNT_W-1:0]  period;
  logic [HOLD_W-1:0] holdCnt;
  logic [REQ_W-1:0]  reqCnt;

  assign baseSel = useFallback ? CNT_W'(FALLBACK_TICKS) : CNT_W'(BASE_TICKS);
  assign period  = baseSel << prescSel;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      holdCnt <= '0;
      reqCnt  <= '0;
      winCnt  <= '0;
    end else begin
      holdCnt <= stb.holdRun ? holdCnt + 1'b1 : '0;
      reqCnt  <= stb.reqRun  ? reqCnt + 1'b1  : '0;
      winCnt  <= (stb.winRun && !stb.winRestart) ? winCnt + 1'b1 : '0;
    end
  end

  assign flags.holdLast = (holdCnt == HOLD_W'(RST_HOLD - 1));
  assign flags.reqLast  = (reqCnt == REQ_W'(REQ_TICKS - 1));
  assign flags.winOpen  = (winCnt >= (period >> 1));
  assign flags.winLast  = (winCnt == period - 1'b1);

  // R4: a running window never passes its period
  assert_win_bound_R4: assert property (@(posedge clk) disable iff (rst)
    stb.winRun |-> (winCnt < period))
    else $error("window counter beyond period");

  // R10: reset hold never passes its length
  assert_hold_bound_R10: assert property (@(posedge clk) disable iff (rst)
    stb.holdRun |-> (holdCnt < HOLD_W'(RST_HOLD)))
    else $error("hold counter beyond limit");

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clrStb,
  input  logic [1:0]  cfgCode,
  input  wdt_flags_t  flags,
  output wdt_strobe_t stb,
  output wdt_mode_e   modeQ,
  output logic        wdOff,
  output logic        refFault
);

  wdt_mode_e modeNext;
  logic      strapOff;

  assign strapOff = (cfgCode == CFG_GND);

  always_comb begin
    modeNext = modeQ;
    stb      = '0;
    unique case (modeQ)
      MODE_RESET: begin
        stb.holdRun = 1'b1;
        if (flags.holdLast) modeNext = strapOff ? MODE_NORMAL : MODE_NREQ;
      end
      MODE_NREQ: begin
        stb.reqRun = 1'b1;
        if (clrStb)             modeNext = MODE_NORMAL;
        else if (flags.reqLast) modeNext = MODE_RESET;
      end
      MODE_NORMAL: begin
        if (!wdOff) begin
          stb.winRun = 1'b1;
          if (clrStb) begin
            if (flags.winOpen) stb.winRestart = 1'b1;
            else               modeNext = MODE_RESET;
          end else if (flags.winLast) begin
            modeNext = MODE_RESET;
          end
        end
      end
      default: modeNext = MODE_RESET;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      modeQ    <= MODE_RESET;
      wdOff    <= 1'b0;
      refFault <= 1'b0;
    end else begin
      modeQ <= modeNext;
      if (modeQ == MODE_RESET) begin
        wdOff    <= strapOff;
        refFault <= cfgCode[1];
      end
    end
  end

  // R3: clear in closed half resets
  assert_early_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NORMAL && !wdOff && clrStb && !flags.winOpen) |=> (modeQ == MODE_RESET))
    else $error("early clear not punished");

  // R2: clear in open half keeps Normal
  assert_good_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NORMAL && !wdOff && clrStb && flags.winOpen) |=> (modeQ == MODE_NORMAL))
    else $error("legal clear rejected");

  // R4: overflow resets
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NORMAL && !wdOff && !clrStb && flags.winLast) |=> (modeQ == MODE_RESET))
    else $error("overflow missed");

  // R5: startup timeout resets
  assert_req_timeout_R5: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NREQ && !clrStb && flags.reqLast) |=> (modeQ == MODE_RESET))
    else $error("startup timeout missed");

  // R7: strapped-off Normal never leaves
  assert_off_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NORMAL && wdOff) |=> (modeQ == MODE_NORMAL))
    else $error("disabled watchdog left Normal");

  // R9: configuration frozen outside Reset
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (modeQ != MODE_RESET) |=> $stable({wdOff, refFault}))
    else $error("config latched outside Reset");

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS     = 40,
  parameter int FALLBACK_TICKS = 24,
  parameter int REQ_TICKS      = 30,
  parameter int RST_HOLD       = 4,
  parameter int PRESC_W        = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clrStb,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic [1:0]         cfgCode,
  output logic               mcuRst,
  output logic [1:0]         mode,
  output logic               wdOff,
  output logic               refFault
);

  wdt_strobe_t stb;
  wdt_flags_t  flags;
  wdt_mode_e   modeQ;

  wdt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clrStb   (clrStb),
    .cfgCode  (cfgCode),
    .flags    (flags),
    .stb      (stb),
    .modeQ    (modeQ),
    .wdOff    (wdOff),
    .refFault (refFault)
  );

  wdt_datapath #(
    .BASE_TICKS     (BASE_TICKS),
    .FALLBACK_TICKS (FALLBACK_TICKS),
    .REQ_TICKS      (REQ_TICKS),
    .RST_HOLD       (RST_HOLD),
    .PRESC_W        (PRESC_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .prescSel    (prescSel),
    .useFallback (refFault),
    .flags       (flags)
  );

  assign mode   = modeQ;
  assign mcuRst = (modeQ == MODE_RESET);

endmodule

// File: tb/wdt_supervisor_bench.sv
module wdt_supervisor_bench;

  localparam int BASE = 40;
  localparam int FB   = 24;
  localparam int REQ  = 30;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clrStb = 1'b0;
  logic [1:0] prescSel = 2'd0;
  logic [1:0] cfgCode = 2'd0;
  logic       mcuRst;
  logic [1:0] mode;
  logic       wdOff;
  logic       refFault;

  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  wdt_supervisor #(
    .BASE_TICKS(BASE), .FALLBACK_TICKS(FB), .REQ_TICKS(REQ), .RST_HOLD(HOLD), .PRESC_W(2)
  ) u_wdt_supervisor (
    .clk(clk), .rst(rst), .clrStb(clrStb), .prescSel(prescSel), .cfgCode(cfgCode),
    .mcuRst(mcuRst), .mode(mode), .wdOff(wdOff), .refFault(refFault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges spent in mode m; R10 mcuRst tracked along the way
  task automatic countMode(input logic [1:0] m, output int n);
    int bad = 0;
    n = 0;
    while (mode == m && n < 2000) begin
      if (mcuRst != (m == 2'd0)) bad++;
      n++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 mcuRst tracks Reset", bad, 0);
  endtask

  task automatic pulseClr();
    clrStb = 1'b1;
    @(negedge clk);
    clrStb = 1'b0;
  endtask

  // reset then release; returns at the negedge where Reset has ended
  task automatic startup(input logic [1:0] cfg, input logic [1:0] ps);
    int n;
    @(negedge clk);
    cfgCode  = cfg;
    prescSel = ps;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    countMode(2'd0, n);
    chk(n == HOLD, "R1 reset hold length", n, HOLD);
  endtask

  task automatic enterNormal(input logic [1:0] cfg, input logic [1:0] ps);
    startup(cfg, ps);
    chk(mode == 2'd1, "R1 enters Normal Request", mode, 1);
    pulseClr();
    chk(mode == 2'd2, "R5 clear enters Normal", mode, 2);
  endtask

  initial begin
    #(8 * 200000);
    vecs++;
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    int p;
    int k;

    // R1 reset state
    repeat (2) @(negedge clk);
    chk(mode == 2'd0, "R1 mode in reset", mode, 0);
    chk(mcuRst == 1'b1, "R1 mcuRst in reset", mcuRst, 1);
    chk({wdOff, refFault} == 2'b00, "R1 status in reset", {wdOff, refFault}, 0);

    // R5 startup timeout and return
    startup(2'd0, 2'd0);
    countMode(2'd1, n);
    chk(n == REQ, "R5 startup timeout", n, REQ);
    chk(mode == 2'd0, "R5 timeout gives Reset", mode, 0);
    countMode(2'd0, n);
    chk(n == HOLD, "R10 hold after timeout", n, HOLD);
    chk(mode == 2'd1, "R5 returns to Normal Request", mode, 1);

    // R4 R6 R8 overflow period over prescaler and timebase
    for (int c = 0; c < 3; c++) begin
      for (int ps = 0; ps < 4; ps++) begin
        logic [1:0] cf;
        cf = (c == 0) ? 2'd0 : ((c == 1) ? 2'd2 : 2'd3);
        p = ((c == 0) ? BASE : FB) << ps;
        enterNormal(cf, 2'(ps));
        chk(refFault == (c != 0), "R8 refFault", refFault, (c != 0));
        chk(wdOff == 1'b0, "R8 wdOff clear", wdOff, 0);
        countMode(2'd2, n);
        chk(n == p, "R4 R6 overflow period", n, p);
        chk(mcuRst == 1'b1, "R4 overflow resets MCU", mcuRst, 1);
      end
    end

    // R2 R3 window boundary sweep, every clear cycle
    for (int c = 0; c < 2; c++) begin
      p = (c == 0) ? BASE : FB;
      for (k = 0; k < p; k++) begin
        enterNormal((c == 0) ? 2'd0 : 2'd2, 2'd0);
        repeat (k) @(negedge clk);
        pulseClr();
        if (k < p / 2) begin
          chk(mode == 2'd0, "R3 early clear resets", mode, 0);
        end else begin
          chk(mode == 2'd2, "R2 late clear accepted", mode, 2);
          countMode(2'd2, n);
          chk(n == p, "R2 window restarts", n, p);
        end
      end
    end

    // R2 repeated servicing with prescaler 1
    enterNormal(2'd0, 2'd1);
    for (int i = 0; i < 5; i++) begin
      repeat (BASE + 3) @(negedge clk);
      pulseClr();
      chk(mode == 2'd2, "R2 periodic service", mode, 2);
    end

    // R7 strapped off
    startup(2'd1, 2'd0);
    chk(mode == 2'd2, "R7 bypasses Normal Request", mode, 2);
    chk(wdOff == 1'b1, "R7 wdOff set", wdOff, 1);
    n = 0;
    for (int i = 0; i < 700; i++) begin
      if (i % 7 == 0) clrStb = 1'b1;
      @(negedge clk);
      clrStb = 1'b0;
      if (mode != 2'd2 || mcuRst) n++;
    end
    chk(n == 0, "R7 no reset when off", n, 0);

    // R9 config changes outside Reset ignored until next Reset
    enterNormal(2'd0, 2'd0);
    cfgCode = 2'd3;
    countMode(2'd2, n);
    chk(n == BASE, "R9 period unchanged", n, BASE);
    chk(refFault == 1'b0, "R9 refFault frozen", refFault, 0);
    cfgCode = 2'd1;
    countMode(2'd0, n);
    chk(mode == 2'd2, "R9 sampled in Reset", mode, 2);
    chk(wdOff == 1'b1, "R9 wdOff latched", wdOff, 1);
    cfgCode = 2'd0;
    repeat (100) @(negedge clk);
    chk(wdOff == 1'b1 && mode == 2'd2, "R9 wdOff frozen", {wdOff, mode}, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule